// File: doc/BRIEF.md
# Bit Field Extract Unit

This unit pulls an unsigned bit field out of a 32-bit register operand and returns it right-justified and zero-extended to 32 bits, along with a set of condition flags describing the field. The caller supplies the operand, a 5-bit starting position and a 5-bit width code, and raises a valid strobe. One clock later the unit presents the extracted value, the flags and an output valid signal.

Bit positions are counted from the most significant end of the operand: position 0 is bit 31. A field that runs past position 31 continues at position 0 of the same operand, so the selection is taken modulo 32. A width code of zero stands for a full 32-bit field.

The flags follow the field. The negative flag copies the field's leading bit, and the zero flag reports an all-zero field. Overflow and carry are always cleared. The extend flag is not computed here: it is taken from an input and passed through with the same latency.

Top module: `bit_field_extract`

## Requirements
- R1: The offset input selects the field's leading bit: offset k maps to operand bit 31-k, so offset 0 is the operand MSB.
- R2: A width code w in 1..31 selects a w-bit field, and a width code of 0 selects a 32-bit field.
- R3: The field is right-justified in `result`, with its leading bit at result bit w-1, and every result bit at or above the field width is 0.
- R4: A field that extends past position 31 continues at position 0, so field bit i (counted from the leading bit) comes from operand bit 31-((offset+i) mod 32).
- R5: `nFlag` is 1 exactly when the field's leading bit is 1.
- R6: `zFlag` is 1 exactly when every bit of the field is 0.
- R7: `vFlag` and `cFlag` are 0 after every extract.
- R8: `xFlag` equals the `xIn` value that was sampled with the valid input.
- R9: Result and flags appear one clock after a cycle with `inValid` high, with `outValid` high for that one cycle. After a cycle with `inValid` low, `outValid` is 0 and the result and flags keep their values.
- R10: A synchronous active-high `rst` clears `outValid`, `result` and all five flags on the next clock edge, even when `inValid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operand, offset and width are valid this cycle |
| srcWord | input | 32 | Register operand |
| fieldOfs | input | 5 | Field start position, 0 = MSB |
| fieldWid | input | 5 | Field width code, 0 = 32 bits |
| xIn | input | 1 | Current extend flag, passed through |
| outValid | output | 1 | Result and flags are new this cycle |
| result | output | 32 | Zero-extended field |
| nFlag | output | 1 | Leading bit of the field |
| zFlag | output | 1 | Field is all zeros |
| vFlag | output | 1 | Overflow, always 0 |
| cFlag | output | 1 | Carry, always 0 |
| xFlag | output | 1 | Extend flag passed through |

## Verification
The unit holds state only in its output registers, so a wrong rotation or mask shows up at `result` in the very cycle after the request, and a wrong flag derivation shows up in `nFlag` or `zFlag` in that same cycle. Sweeping every offset and width code, including the wrapping fields and the full-width code, means that any wrong bit routing is caught within a single request. A wrong load strobe shows as `outValid` out of step with `inValid`, or as outputs that change during idle cycles, one cycle after the bad strobe.

// File: rtl/bfx_pkg.sv
package bfx_pkg;

  // Strobes sent from control to the datapath each cycle.
  typedef struct packed {
    logic load;   // capture a new field and flags
    logic clear;  // zero all output registers
  } bfxStrobe_t;

endpackage

// File: rtl/bfx_ctrl.sv
module bfx_ctrl
  import bfx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  output bfxStrobe_t strobe,
  output logic       outValid
);

  always_comb begin
    strobe.clear = rst;
    strobe.load  = inValid & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

  // R9: output valid follows input valid by exactly one cycle
  a_r9_valid_latency: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  a_r9_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

endmodule

// File: rtl/bfx_datapath.sv
module bfx_datapath
  import bfx_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int OFS_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  bfxStrobe_t        strobe,
  input  logic [DATA_W-1:0] srcWord,
  input  logic [OFS_W-1:0]  fieldOfs,
  input  logic [OFS_W-1:0]  fieldWid,
  input  logic              xIn,
  output logic [DATA_W-1:0] result,
  output logic              nFlag,
  output logic              zFlag,
  output logic              vFlag,
  output logic              cFlag,
  output logic              xFlag
);

  localparam logic [OFS_W:0] FULL_LEN = (OFS_W+1)'(DATA_W);

  logic [2*DATA_W-1:0] doubled;
  logic [DATA_W-1:0]   rotated;
  logic [OFS_W:0]      wLen;
  logic [OFS_W:0]      dropBits;
  logic [DATA_W-1:0]   fieldVal;
  logic [OFS_W-1:0]    topIdx;

  // Rotate so that the field's leading bit lands on the MSB; the doubled
  // word makes positions past the end wrap back to the start (R1, R4).
  assign doubled = {srcWord, srcWord};
  assign rotated = doubled[2*DATA_W-1-fieldOfs -: DATA_W];

  // Width code zero means full width (R2).
  assign wLen     = (fieldWid == '0) ? FULL_LEN : {1'b0, fieldWid};
  assign dropBits = FULL_LEN - wLen;
  assign fieldVal = rotated >> dropBits;     // right-justify, zero-fill (R3)
  assign topIdx   = OFS_W'(wLen - 1'b1);

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      result <= '0;
      nFlag  <= 1'b0;
      zFlag  <= 1'b0;
      vFlag  <= 1'b0;
      cFlag  <= 1'b0;
      xFlag  <= 1'b0;
    end else if (strobe.load) begin
      result <= fieldVal;
      nFlag  <= rotated[DATA_W-1];          // leading bit of field (R5)
      zFlag  <= (fieldVal == '0);           // (R6)
      vFlag  <= 1'b0;                       // (R7)
      cFlag  <= 1'b0;
      xFlag  <= xIn;                        // (R8)
    end
  end

  // R3: nothing above the field width survives
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
    strobe.load |=> ((result >> $past(wLen)) == '0));
  // R5: N tracks the top bit of the stored field
  a_r5_n_is_top: assert property (@(posedge clk) disable iff (rst)
    strobe.load |=> (nFlag == result[$past(topIdx)]));
  // R6: Z agrees with the stored result
  a_r6_z_matches: assert property (@(posedge clk) disable iff (rst)
    strobe.load |=> (zFlag == (result == '0)));
  // R8: X comes from the input sampled with the request
  a_r8_x_pass: assert property (@(posedge clk) disable iff (rst)
    strobe.load |=> (xFlag == $past(xIn)));
  // R9: outputs hold while idle
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (!strobe.load && !strobe.clear) |=> ($stable(result) && $stable(nFlag) && $stable(zFlag) && $stable(xFlag)));
  // R10: reset clears the registers
  a_r10_reset_clear: assert property (@(posedge clk)
    strobe.clear |=> (result == '0 && !nFlag && !zFlag && !xFlag));

endmodule

// File: rtl/bit_field_extract.sv
module bit_field_extract
  import bfx_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int OFS_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] srcWord,
  input  logic [OFS_W-1:0]  fieldOfs,
  input  logic [OFS_W-1:0]  fieldWid,
  input  logic              xIn,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              nFlag,
  output logic              zFlag,
  output logic              vFlag,
  output logic              cFlag,
  output logic              xFlag
);

  bfxStrobe_t strobe;

  bfx_ctrl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  bfx_datapath #(.DATA_W(DATA_W)) uData (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .srcWord  (srcWord),
    .fieldOfs (fieldOfs),
    .fieldWid (fieldWid),
    .xIn      (xIn),
    .result   (result),
    .nFlag    (nFlag),
    .zFlag    (zFlag),
    .vFlag    (vFlag),
    .cFlag    (cFlag),
    .xFlag    (xFlag)
  );

  // R7: overflow and carry never set
  a_r7_vc_low: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (!vFlag && !cFlag));

endmodule

// File: tb/sim_bit_field_extract.sv
module sim_bit_field_extract;

  logic        clk = 1'b0;
  logic        rst;
  logic        inValid;
  logic [31:0] srcWord;
  logic [4:0]  fieldOfs;
  logic [4:0]  fieldWid;
  logic        xIn;
  logic        outValid;
  logic [31:0] result;
  logic        nFlag, zFlag, vFlag, cFlag, xFlag;

  int testsRun = 0;
  int testsFail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bit_field_extract u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .srcWord(srcWord),
    .fieldOfs(fieldOfs), .fieldWid(fieldWid), .xIn(xIn),
    .outValid(outValid), .result(result), .nFlag(nFlag), .zFlag(zFlag),
    .vFlag(vFlag), .cFlag(cFlag), .xFlag(xFlag)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Reference: walk the field bit by bit from its leading position.
  function automatic logic [31:0] refField(logic [31:0] s, int ofs, int wc);
    int len = (wc == 0) ? 32 : wc;
    logic [31:0] acc = '0;
    for (int i = 0; i < len; i++) begin
      int pos = 31 - ((ofs + i) % 32);
      acc = {acc[30:0], s[pos]};
    end
    return acc;
  endfunction

  task automatic runOp(logic [31:0] s, int ofs, int wc, logic x, string tag);
    logic [31:0] exp;
    int len;
    len = (wc == 0) ? 32 : wc;
    exp = refField(s, ofs, wc);
    @(negedge clk);
    srcWord = s; fieldOfs = 5'(ofs); fieldWid = 5'(wc); xIn = x; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check({tag, " R1 R2 R3 R4 result"}, result, exp);
    check("R5 nFlag", {31'b0, nFlag}, {31'b0, exp[len-1]});
    check("R6 zFlag", {31'b0, zFlag}, {31'b0, exp == 0});
    check("R7 vFlag/cFlag", {30'b0, vFlag, cFlag}, 32'd0);
    check("R8 xFlag", {31'b0, xFlag}, {31'b0, x});
    check("R9 outValid", {31'b0, outValid}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      testsRun++; testsFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    rst = 1'b1; inValid = 1'b0; srcWord = '0; fieldOfs = '0; fieldWid = '0; xIn = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 reset outValid", {31'b0, outValid}, 32'd0);
    check("R10 reset result", result, 32'd0);
    check("R10 reset flags", {27'b0, nFlag, zFlag, vFlag, cFlag, xFlag}, 32'd0);
    rst = 1'b0;

    // Explicit corners
    runOp(32'hDEADBEEF, 0, 0, 1'b1, "full width wc=0");
    runOp(32'h80000001, 31, 2, 1'b0, "wrap ofs31 w2");     // expect 3
    runOp(32'h12345678, 16, 0, 1'b1, "full wrap ofs16");   // expect 5678_1234
    runOp(32'h00000000, 5, 7, 1'b0, "zero field");
    runOp(32'h80000000, 0, 1, 1'b1, "msb single");
    runOp(32'h00000001, 31, 1, 1'b0, "lsb single");
    runOp(32'hF000000F, 28, 8, 1'b1, "wrap across end");

    // Full sweep of offsets and width codes with random operands
    for (int o = 0; o < 32; o++)
      for (int w = 0; w < 32; w++)
        runOp($urandom, o, w, 1'($urandom), "sweep");

    // R9 hold while idle
    runOp(32'hA5A5A5A5, 3, 9, 1'b1, "pre-hold");
    held = result;
    @(negedge clk);
    srcWord = 32'h0; fieldOfs = 5'd0; fieldWid = 5'd4; xIn = 1'b0;
    @(negedge clk);
    check("R9 idle outValid low", {31'b0, outValid}, 32'd0);
    check("R9 idle result held", result, held);
    check("R9 idle xFlag held", {31'b0, xFlag}, 32'd1);

    // R10 reset while a request is presented
    @(negedge clk);
    rst = 1'b1; inValid = 1'b1; srcWord = 32'hFFFFFFFF; fieldWid = 5'd0;
    @(negedge clk);
    check("R10 reset over valid outValid", {31'b0, outValid}, 32'd0);
    check("R10 reset over valid result", result, 32'd0);
    check("R10 reset over valid flags", {27'b0, nFlag, zFlag, vFlag, cFlag, xFlag}, 32'd0);
    rst = 1'b0; inValid = 1'b0;
    runOp(32'h0F0F0F0F, 4, 4, 1'b0, "after reset");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

endmodule